// File: doc/BRIEF.md
# Fair Ticket Lock Arbiter

This block guards one shared resource for a fixed set of requesters and hands it out in the order the requests arrived. When a requester asks for the lock, it draws a number from a central counter and the counter moves on in the same step. A separate "serving" register names the number that currently owns the lock. A requester holds the lock while the serving value equals its number. When the holder gives the lock back, the serving value steps forward by one and the lock passes to the next number in line.

Each requester has an acquire strobe and a release strobe, and it receives a grant line and a view of the number it drew. The counters are `$clog2(N_REQ)+1` bits wide and wrap around. At most N_REQ numbers are ever outstanding, so the equality test stays correct across the wrap. Acquires that arrive together in one cycle get consecutive numbers, with the lowest port index served first. A release from a port that does not hold the grant has no effect. An acquire from a port that already holds a number also has no effect.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset all grant bits are 0, every ticket field reads 0, and the first ticket issued is 0.
- R2: A port that is idle and sees its acquire bit sampled at a clock edge shows, in its ticket field `ticket_o[i*TW +: TW]` after that edge, the counter value present before the edge. The counter then advances by one.
- R3: Several idle ports that acquire in the same cycle receive consecutive tickets, with lower port indices taking lower tickets.
- R4: Grant is registered. A port whose ticket equals the serving value after edge k has its grant bit set after edge k+1. On a free lock, a port acquired at edge k is therefore granted after edge k+1.
- R5: At most one grant bit is high in any cycle.
- R6: A release from the holder clears its grant after that edge and advances the serving value by one. The waiting port holding the next ticket is granted one edge later.
- R7: A release strobe from a port whose grant is low changes no grant and no ticket.
- R8: An acquire from a port that already holds a ticket, whether waiting or granted, leaves its ticket unchanged and does not advance the counter.
- R9: Grants are given in exactly the order in which acquires were accepted, with same-cycle acquires ordered by port index.
- R10: The ticket and serving counters wrap modulo 2^TW, and issue and grant stay correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_i | input | N_REQ | Per-port acquire strobe |
| rel_i | input | N_REQ | Per-port release strobe |
| grant_o | output | N_REQ | Per-port registered grant |
| ticket_o | output | N_REQ*TW | Ticket drawn by each port; field i sits at bits i*TW +: TW |

## Verification
Two things can happen in the same cycle: the holder releases while one or more other ports acquire. In that case the serving value advances at the same edge that new tickets are drawn. The bench provokes this in a directed step and, more often, in a long phase with mixed strobes, where the release mask often copies the live grant. A reference model computes the ticket and the grant owner in every cycle. A scoreboard queue, filled in acceptance order, is compared against each rising grant. Together they show that a release and an acquire in the same cycle neither lose a ticket nor reorder the line.

// File: rtl/tlk_pkg.sv
package tlk_pkg;

    parameter int unsigned TLK_REQ_DEF = 4;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_OWN  = 2'd2
    } slot_e;

    typedef struct packed {
        logic take;
        logic drop;
    } slot_cmd_t;

    function automatic int unsigned tkt_width(input int unsigned n);
        return $clog2(n) + 1;
    endfunction

endpackage

// File: rtl/tlk_issue.sv
module tlk_issue #(
    parameter int unsigned N_REQ = 4,
    parameter int unsigned TW    = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_REQ-1:0]           take_i,
    output logic [N_REQ-1:0][TW-1:0]   give_o
);
    logic [TW-1:0] nxt_q;
    logic [TW-1:0] run;

    // port 0 draws first, then ascending index
    always_comb begin
        run = nxt_q;
        for (int i = 0; i < int'(N_REQ); i++) begin
            give_o[i] = run;
            if (take_i[i]) run = run + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) nxt_q <= '0;
        else     nxt_q <= run;
    end
endmodule

// File: rtl/tlk_serve.sv
module tlk_serve #(
    parameter int unsigned TW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv_i,
    output logic [TW-1:0] srv_o
);
    always_ff @(posedge clk) begin
        if (rst)        srv_o <= '0;
        else if (adv_i) srv_o <= srv_o + TW'(1);
    end
endmodule

// File: rtl/tlk_slot.sv
module tlk_slot
    import tlk_pkg::*;
#(
    parameter int unsigned TW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  slot_cmd_t     cmd_i,
    input  logic [TW-1:0] give_i,
    input  logic [TW-1:0] srv_i,
    output logic          busy_o,
    output logic          own_o,
    output logic [TW-1:0] tkt_o
);
    slot_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SLOT_IDLE;
            tkt_o <= '0;
        end else begin
            unique case (st_q)
                SLOT_IDLE: if (cmd_i.take) begin
                    st_q  <= SLOT_WAIT;
                    tkt_o <= give_i;
                end
                SLOT_WAIT: if (tkt_o == srv_i) st_q <= SLOT_OWN;
                SLOT_OWN:  if (cmd_i.drop) st_q <= SLOT_IDLE;
                default:   st_q <= SLOT_IDLE;
            endcase
        end
    end

    assign busy_o = (st_q != SLOT_IDLE);
    assign own_o  = (st_q == SLOT_OWN);
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit
    import tlk_pkg::*;
#(
    parameter int unsigned N_REQ = TLK_REQ_DEF,
    parameter int unsigned TW    = tkt_width(N_REQ)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_REQ-1:0]      acq_i,
    input  logic [N_REQ-1:0]      rel_i,
    output logic [N_REQ-1:0]      grant_o,
    output logic [N_REQ*TW-1:0]   ticket_o
);
    logic [N_REQ-1:0]         busy;
    logic [N_REQ-1:0]         take;
    logic [N_REQ-1:0]         drop;
    logic [N_REQ-1:0][TW-1:0] give;
    logic [TW-1:0]            srv;

    assign take = acq_i & ~busy;
    assign drop = rel_i & grant_o;

    tlk_issue #(.N_REQ(N_REQ), .TW(TW)) issue_i (
        .clk(clk), .rst(rst), .take_i(take), .give_o(give)
    );

    tlk_serve #(.TW(TW)) serve_i (
        .clk(clk), .rst(rst), .adv_i(|drop), .srv_o(srv)
    );

    for (genvar g = 0; g < int'(N_REQ); g++) begin : g_slot
        slot_cmd_t cmd;
        assign cmd.take = take[g];
        assign cmd.drop = drop[g];
        tlk_slot #(.TW(TW)) slot_i (
            .clk(clk), .rst(rst), .cmd_i(cmd), .give_i(give[g]), .srv_i(srv),
            .busy_o(busy[g]), .own_o(grant_o[g]), .tkt_o(ticket_o[g*TW +: TW])
        );
    end
endmodule

// File: rtl/ticket_lock_unit_chk.sv
module ticket_lock_unit_chk #(
    parameter int unsigned N_REQ = 4,
    parameter int unsigned TW    = 3
) (
    input logic                clk,
    input logic                rst,
    input logic [N_REQ-1:0]    acq_i,
    input logic [N_REQ-1:0]    rel_i,
    input logic [N_REQ-1:0]    grant_o,
    input logic [N_REQ*TW-1:0] ticket_o
);
    p_one_grant_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    p_rel_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (|(rel_i & grant_o)) |=> ((grant_o & $past(grant_o)) == '0));

    p_stray_rel_r7: assert property (@(posedge clk) disable iff (rst)
        ((|grant_o) && ((rel_i & grant_o) == '0)) |=> $stable(grant_o));

    for (genvar g = 0; g < int'(N_REQ); g++) begin : g_hold
        p_hold_tkt_r8: assert property (@(posedge clk) disable iff (rst)
            grant_o[g] |=> $stable(ticket_o[g*TW +: TW]));
    end

    // acq_i is unused by the properties above
    logic unused_acq;
    assign unused_acq = ^acq_i;
endmodule

bind ticket_lock_unit ticket_lock_unit_chk #(.N_REQ(N_REQ), .TW(TW)) chk_i (
    .clk(clk), .rst(rst), .acq_i(acq_i), .rel_i(rel_i),
    .grant_o(grant_o), .ticket_o(ticket_o)
);

// File: tb/ticket_lock_unit_tb_top.sv
`timescale 1ns/1ps
module ticket_lock_unit_tb_top;
    localparam int N  = 4;
    localparam int TW = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    acq = '0;
    logic [N-1:0]    rel = '0;
    logic [N-1:0]    grant_o;
    logic [N*TW-1:0] ticket_o;

    int n_run  = 0;
    int n_fail = 0;

    bit            m_has [N];
    bit            m_own [N];
    logic [TW-1:0] m_tkt [N];
    logic [TW-1:0] m_nxt = '0;
    logic [TW-1:0] m_srv = '0;
    int            sb_q[$];
    logic [N-1:0]  prev_g = '0;
    bit            mon_on = 1'b0;

    always #10 clk = ~clk;

    ticket_lock_unit #(.N_REQ(N)) dut_i (
        .clk(clk), .rst(rst), .acq_i(acq), .rel_i(rel),
        .grant_o(grant_o), .ticket_o(ticket_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] a, input logic [N-1:0] r, input string tag);
        bit nown [N];
        bit adv;
        acq = a;
        rel = r;
        @(posedge clk);
        adv = 1'b0;
        for (int i = 0; i < N; i++)
            nown[i] = m_own[i] ? !r[i] : (m_has[i] && m_tkt[i] == m_srv);
        for (int i = 0; i < N; i++) begin
            if (m_own[i] && r[i]) begin
                adv = 1'b1;
                m_has[i] = 1'b0;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (a[i] && !m_has[i] && !(m_own[i] && r[i])) begin
                m_has[i] = 1'b1;
                m_tkt[i] = m_nxt;
                m_nxt    = m_nxt + 1'b1;
                sb_q.push_back(i);
            end
        end
        if (adv) m_srv = m_srv + 1'b1;
        for (int i = 0; i < N; i++) m_own[i] = nown[i];
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            check(grant_o[i] == m_own[i], tag, $sformatf("grant[%0d]", i),
                  int'(grant_o[i]), int'(m_own[i]));
            if (m_has[i])
                check(ticket_o[i*TW +: TW] == m_tkt[i], tag, $sformatf("ticket[%0d]", i),
                      int'(ticket_o[i*TW +: TW]), int'(m_tkt[i]));
        end
    endtask

    // scoreboard monitor: each rising grant must match the oldest accepted acquire (R9)
    always @(negedge clk) begin
        if (mon_on) begin
            for (int i = 0; i < N; i++) begin
                if (grant_o[i] && !prev_g[i]) begin
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R9", "grant with empty queue", i, -1);
                    end else begin
                        int e;
                        e = sb_q.pop_front();
                        check(e == i, "R9", "grant order", i, e);
                    end
                end
            end
        end
        prev_g = grant_o;
    end

    initial begin
        #(20 * 60000);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_has[i] = 1'b0; m_own[i] = 1'b0; m_tkt[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(grant_o == '0, "R1", "grants after reset", int'(grant_o), 0);
        check(ticket_o == '0, "R1", "tickets after reset", int'(ticket_o), 0);
        mon_on = 1'b1;

        step(4'b0100, 4'b0000, "R1");   // first ticket is 0 (also R2)
        check(ticket_o[2*TW +: TW] == 3'd0, "R2", "first drawn ticket", int'(ticket_o[2*TW +: TW]), 0);
        check(grant_o == '0, "R4", "no grant one edge after acquire", int'(grant_o), 0);
        step(4'b0000, 4'b0000, "R4");
        check(grant_o == 4'b0100, "R4", "grant two edges after acquire", int'(grant_o), 4);
        step(4'b0000, 4'b0100, "R6");
        step(4'b1111, 4'b0000, "R3");
        check(ticket_o[0 +: TW] == 3'd1, "R3", "port0 ticket", int'(ticket_o[0 +: TW]), 1);
        check(ticket_o[3*TW +: TW] == 3'd4, "R3", "port3 ticket", int'(ticket_o[3*TW +: TW]), 4);
        step(4'b0000, 4'b0000, "R4");
        step(4'b0000, 4'b1000, "R7");
        check(grant_o == 4'b0001, "R7", "stray release ignored", int'(grant_o), 1);
        step(4'b0011, 4'b0000, "R8");
        check(ticket_o[TW +: TW] == 3'd2, "R8", "repeat acquire keeps ticket", int'(ticket_o[TW +: TW]), 2);
        step(4'b0000, 4'b0001, "R6");
        step(4'b0001, 4'b0000, "R6");   // rejoin while lock passes to port1
        check(grant_o == 4'b0010, "R6", "next ticket granted", int'(grant_o), 2);
        step(4'b0100, 4'b0010, "R6");   // acquire refused (port2 busy) with release in same cycle
        repeat (14) step(4'b0000, grant_o, "R9");
        check(sb_q.size() == 0, "R9", "queue drained", sb_q.size(), 0);

        for (int k = 0; k < 600; k++) begin
            logic [N-1:0] a;
            logic [N-1:0] r;
            a = N'($urandom);
            r = ($urandom % 3 != 0) ? grant_o : N'($urandom);
            step(a, r, "R10");
        end
        repeat (20) step(4'b0000, grant_o, "R10");
        check(sb_q.size() == 0, "R9", "queue drained after wrap", sb_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule